// File: doc/BRIEF.md
# Supply Lockout Gate with Hold-off Release

This block sits in front of a memory and keeps it closed while the supply is not fit for use. An external comparator gives a digital "supply above threshold" level. The block first passes that level through a synchronizer. From it the block derives an active-low status flag, `supply_low_n`, and an internal access window. The flag is low out of reset and stays low while the supply is low. When the supply recovers, a hold-off counter has to run its full length before the flag rises and the memory opens. A supply drop closes the memory at once and cancels any hold-off that is running.

Requests arrive on a valid/ready stream and leave on a second valid/ready stream toward the memory. While the window is open the two streams are joined: `req_ready` follows `mem_req_ready`, so the memory applies back-pressure straight to the requester, and a request counts as accepted on an edge where `req_valid` and `req_ready` are both high. While the window is closed every request is accepted at once and nothing reaches the memory. A blocked read gets a zero response, and each blocked request raises `blocked_pulse`. The response path has no ready signal, so the requester must always be able to take a response.

Top module: `supply_guard`

## Requirements
- R1: While `rst_n` is low, and at the first edge after reset, `supply_low_n` is 0, `mem_req_valid` is 0, `rsp_valid` is 0 and `blocked_pulse` is 0.
- R2: The `supply_ok` input goes through a chain of `SYNC_STAGES` flops (default 2) before any logic uses it. While the synchronized level is 0, `supply_low_n` is 0.
- R3: Take the first rising edge that samples `supply_ok` high as edge 1. Then, with the default two-stage synchronizer, `supply_low_n` rises just after edge `HOLDOFF_CYC`+3, and not earlier.
- R4: If `supply_ok` falls during the hold-off, the counter is cleared and `supply_low_n` stays 0. Release then takes a full hold-off again, measured from the edge that samples the input high once more.
- R5: Once released, `supply_low_n` stays 1 for as long as `supply_ok` stays high.
- R6: Take the first edge that samples `supply_ok` low as edge 1. Then `supply_low_n` falls just after edge 2, and the memory is closed from that point on.
- R7: While `supply_low_n` is 0, `mem_req_valid` is 0 and `req_ready` is 1.
- R8: A read accepted while locked gives `rsp_valid`=1 with `rsp_rdata`=0 one cycle after it is accepted.
- R9: Each request accepted while locked raises `blocked_pulse` for exactly one cycle, one cycle after it is accepted. A blocked write leaves memory contents unchanged.
- R10: While `supply_low_n` is 1, `mem_req_valid`=`req_valid` and `req_ready`=`mem_req_ready`. Write, address and data pass through unchanged, and memory responses are forwarded on `rsp_valid`/`rsp_rdata`.
- R11: A memory response (`mem_rsp_valid`) that arrives while `supply_low_n` is 0 is discarded and produces no `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Comparator level, 1 = supply above threshold |
| supply_low_n | output | 1 | Active-low status: 0 = supply low or hold-off running |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| mem_req_valid | output | 1 | Request toward memory valid |
| mem_req_ready | input | 1 | Memory can take a request |
| mem_req_write | output | 1 | Forwarded write flag |
| mem_req_addr | output | ADDR_W | Forwarded address |
| mem_req_wdata | output | DATA_W | Forwarded write data |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_rdata | input | DATA_W | Memory read data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | DATA_W | Read response data |
| blocked_pulse | output | 1 | One-cycle pulse per blocked request |

## Verification
The supply input is driven with a clean rise, a drop from the released state, and a short dip in the middle of a hold-off. Measuring the edge count to each flag change tells an exact hold-off length apart from one that is off by one, and it shows whether the count is cancelled or only paused. Access is tried while open, both with and without memory back-pressure, and while locked, using reads, writes and a blocked write followed by a read-back once the memory reopens. One read is placed so that its memory response lands just after lockout, which tells a discarded response apart from a forwarded one.

// File: rtl/supply_guard_pkg.sv
`timescale 1ns/1ps
package supply_guard_pkg;

  typedef enum logic [1:0] {
    GRD_LOCKED = 2'd0,
    GRD_WAIT   = 2'd1,
    GRD_OPEN   = 2'd2
  } grd_state_t;

  // width able to hold 0 .. n-1 (at least one bit)
  function automatic int unsigned cnt_bits(input int unsigned n);
    int unsigned b;
    b = 1;
    while ((1 << b) < n) b++;
    return b;
  endfunction

endpackage

// File: rtl/sg_sync.sv
`timescale 1ns/1ps
module sg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);

  logic [STAGES-1:0] chain_q;

  generate
    genvar gi;
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b0;
          else        chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/sg_holdoff.sv
`timescale 1ns/1ps
module sg_holdoff
  import supply_guard_pkg::*;
#(
  parameter int unsigned HOLDOFF_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ok_sync,
  output logic open
);

  localparam int unsigned CW = cnt_bits(HOLDOFF_CYC);
  localparam logic [CW-1:0] LAST = CW'(HOLDOFF_CYC - 1);

  grd_state_t state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      GRD_LOCKED: begin
        cnt_d = '0;
        if (ok_sync) state_d = GRD_WAIT;
      end
      GRD_WAIT: begin
        if (!ok_sync) begin
          state_d = GRD_LOCKED;
          cnt_d   = '0;
        end else if (cnt_q == LAST) begin
          state_d = GRD_OPEN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      GRD_OPEN: begin
        if (!ok_sync) state_d = GRD_LOCKED;
      end
      default: begin
        state_d = GRD_LOCKED;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GRD_LOCKED;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // a low synchronized level closes the window in the same cycle
  assign open = (state_q == GRD_OPEN) && ok_sync;

endmodule

// File: rtl/sg_gate.sv
`timescale 1ns/1ps
module sg_gate #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              blocked_pulse
);

  logic blk_take;
  logic blk_rd_q, blk_any_q;

  assign req_ready     = open ? mem_req_ready : 1'b1;
  assign mem_req_valid = req_valid && open;
  assign mem_req_write = req_write;
  assign mem_req_addr  = req_addr;
  assign mem_req_wdata = req_wdata;

  assign blk_take = req_valid && !open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_rd_q  <= 1'b0;
      blk_any_q <= 1'b0;
    end else begin
      blk_rd_q  <= blk_take && !req_write;
      blk_any_q <= blk_take;
    end
  end

  // release needs at least one hold-off cycle after a lock, so a
  // blocked reply never meets a forwarded one
  assign rsp_valid     = blk_rd_q || (mem_rsp_valid && open);
  assign rsp_rdata     = blk_rd_q ? '0 : mem_rsp_rdata;
  assign blocked_pulse = blk_any_q;

endmodule

// File: rtl/supply_guard.sv
`timescale 1ns/1ps
module supply_guard #(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned HOLDOFF_CYC = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  output logic              supply_low_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              blocked_pulse
);

  logic ok_sync;
  logic open;

  sg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (supply_ok),
    .d_out (ok_sync)
  );

  sg_holdoff #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .ok_sync (ok_sync),
    .open    (open)
  );

  sg_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .open          (open),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .blocked_pulse (blocked_pulse)
  );

  assign supply_low_n = open;

endmodule

// File: rtl/supply_guard_chk.sv
`timescale 1ns/1ps
module supply_guard_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ok_sync,
  input logic              supply_low_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              blocked_pulse
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) reset_flag_chk: assert (!supply_low_n && !blocked_pulse);
  end

  // R2
  sync_low_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_sync |-> !supply_low_n);

  // R7
  locked_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_low_n |-> (!mem_req_valid && req_ready));

  // R8
  blocked_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !supply_low_n && !req_write) |=> (rsp_valid && rsp_rdata == '0));

  // R9
  blocked_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !supply_low_n) |=> blocked_pulse);

  // R9
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_pulse |-> $past(req_valid && !supply_low_n));

  // R10
  open_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low_n |-> (req_ready == mem_req_ready && mem_req_valid == req_valid));

  // R5
  stays_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_low_n && ok_sync) |=> (supply_low_n || !ok_sync));

endmodule

bind supply_guard supply_guard_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ok_sync       (ok_sync),
  .supply_low_n  (supply_low_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_write     (req_write),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_rdata     (rsp_rdata),
  .blocked_pulse (blocked_pulse)
);

// File: tb/supply_guard_tb.sv
`timescale 1ns/1ps
module supply_guard_tb;

  localparam int unsigned AW   = 8;
  localparam int unsigned DW   = 8;
  localparam int unsigned HOLD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic supply_low_n;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic mem_req_valid;
  logic mem_req_ready = 1'b1;
  logic mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_rdata = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic blocked_pulse;

  always #2.5 clk = ~clk;

  supply_guard #(.ADDR_W(AW), .DATA_W(DW), .HOLDOFF_CYC(HOLD), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .supply_low_n(supply_low_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .blocked_pulse(blocked_pulse)
  );

  // memory model and its shadow copy
  logic [DW-1:0] bmem [0:(1<<AW)-1];
  logic [DW-1:0] shadow [0:(1<<AW)-1];
  initial begin
    for (int i = 0; i < (1<<AW); i++) begin
      bmem[i]   = DW'(i) ^ 8'hA5;
      shadow[i] = DW'(i) ^ 8'hA5;
    end
  end

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        bmem[mem_req_addr] <= mem_req_wdata;
        mem_rsp_valid <= 1'b0;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= bmem[mem_req_addr];
      end
    end else begin
      mem_rsp_valid <= 1'b0;
    end
  end

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [DW-1:0] exp_q [$];
  logic [8*4-1:0] exp_tag_q [$];
  int exp_pulses = 0;
  int seen_pulses = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // monitor: pops the scoreboard on each response
  always @(negedge clk) begin
    if (rst_n) begin
      if (blocked_pulse) seen_pulses++;
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R11 unexpected response", int'(rsp_rdata), -1);
        end else begin
          logic [DW-1:0] e;
          logic [8*4-1:0] t;
          e = exp_q.pop_front();
          t = exp_tag_q.pop_front();
          chk(rsp_rdata == e, string'(t), int'(rsp_rdata), int'(e));
        end
      end
    end
  end

  // driver: one request, expected result pushed to the scoreboard
  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit exp_open);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #0.5;
    while (!req_ready) begin
      @(negedge clk);
      #0.5;
    end
    if (exp_open) begin
      chk(mem_req_valid && mem_req_addr == a && mem_req_write == wr && mem_req_wdata == d,
          "R10 pass-through", int'(mem_req_addr), int'(a));
      if (wr) shadow[a] = d;
      else begin exp_q.push_back(shadow[a]); exp_tag_q.push_back("R10 "); end
    end else begin
      chk(!mem_req_valid && req_ready, "R7 locked request", int'(mem_req_valid), 0);
      exp_pulses++;
      if (!wr) begin exp_q.push_back('0); exp_tag_q.push_back("R8  "); end
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic count_until(input bit lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (supply_low_n != lvl && n < 200);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1
    chk(!supply_low_n && !mem_req_valid && !rsp_valid && !blocked_pulse,
        "R1 reset state", int'(supply_low_n), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!supply_low_n, "R2 low while supply low", int'(supply_low_n), 0);

    // blocked read and write while locked (R8, R9)
    do_req(0, 8'h10, 8'h00, 0);
    do_req(1, 8'h05, 8'h3C, 0);

    // clean rise (R3)
    @(negedge clk);
    supply_ok = 1'b1;
    count_until(1'b1, n);
    chk(n == HOLD + 3, "R3 release delay", n, HOLD + 3);

    // stays released (R5)
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!supply_low_n) n++;
    end
    chk(n == 0, "R5 stays released", n, 0);

    // open traffic (R10, R9 blocked write left memory alone)
    do_req(0, 8'h05, 8'h00, 1);
    do_req(1, 8'h20, 8'h77, 1);
    do_req(0, 8'h20, 8'h00, 1);
    do_req(0, 8'h33, 8'h00, 1);

    // back-pressure (R10)
    @(negedge clk);
    mem_req_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h44;
    #0.5;
    chk(!req_ready && mem_req_valid && mem_req_addr == 8'h44, "R10 back-pressure",
        int'(req_ready), 0);
    @(negedge clk);
    mem_req_ready = 1'b1;
    exp_q.push_back(shadow[8'h44]); exp_tag_q.push_back("R10 ");
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);

    // drop from released state (R6)
    supply_ok = 1'b0;
    count_until(1'b0, n);
    chk(n == 2, "R6 lock delay", n, 2);
    do_req(1, 8'h20, 8'h11, 0);
    do_req(0, 8'h20, 8'h00, 0);

    // dip during hold-off (R4)
    @(negedge clk);
    supply_ok = 1'b1;
    repeat (4) @(negedge clk);
    chk(!supply_low_n, "R4 low during hold-off", int'(supply_low_n), 0);
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    count_until(1'b1, n);
    chk(n == HOLD + 3, "R4 full restart after dip", n, HOLD + 3);

    // R9: blocked write to 0x20 did not land
    do_req(0, 8'h20, 8'h00, 1);
    repeat (3) @(negedge clk);

    // response landing just after lockout (R11)
    supply_ok = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h07;
    #0.5;
    chk(supply_low_n && req_ready, "R11 setup open", int'(supply_low_n), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!supply_low_n && !rsp_valid, "R11 response discarded", int'(rsp_valid), 0);
    repeat (4) @(negedge clk);

    chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
    chk(seen_pulses == exp_pulses, "R9 pulse count", seen_pulses, exp_pulses);
    summary();
  end

endmodule